// File: doc/BRIEF.md
# Registered Multi-Function ALU with Flag Freeze

This block is a small integer arithmetic and logic unit. Two operands of `W` bits, an auxiliary carry bit, a 4-bit operation code and a 4-bit shift distance go in. A result twice the operand width and a 4-bit flag vector come out. Both outputs are captured in registers on the rising clock edge, so each result appears one cycle after its inputs. The result is wide enough to hold a full product.

Inside the block, a decoder turns the operation code into one-hot unit selects and a flag-update enable. Parallel units then compute the sum or difference, the product, the bitwise logic, the shifts and the comparison. An output multiplexer picks the result and forms the flags. When the freeze input is high, the flag register loads the externally supplied flag vector instead of the computed flags. Software can use this to keep the flags of an earlier operation while the result register keeps updating.

Top module: `alu_bypass_top`

## Requirements
- R1: A synchronous active-high reset clears `r` and `status` to zero at the next rising edge.
- R2: Code 0 (add) gives `r = a + b + cin` one cycle later, with the carry-out in `r[W]` and zeros above it.
- R3: Code 1 (subtract) gives `a - b` modulo 2^W in `r[W-1:0]`, with `r[W]` = 1 exactly when `a >= b` (unsigned). All higher bits are zero and `cin` has no effect.
- R4: Code 2 (multiply) gives the full unsigned product `a * b` on all 2W bits of `r`.
- R5: The logic codes give a result on `r[W-1:0]` with the upper half zero: 3 `~a`, 4 `a&b`, 5 `~(a&b)`, 6 `a|b`, 7 `~(a|b)`, 8 `a^b`, 9 `~(a^b)`.
- R6: Code 10 gives `a` shifted left and code 11 gives `a` shifted right, logically, by `shamt` places, keeping W bits. A distance of W or more gives zero, and the upper half is zero.
- R7: Code 12 sets `r` to 1 when `a < b` (unsigned) and to 0 otherwise.
- R8: Codes 13 to 15 give `r = 0`.
- R9: With `freeze` low, `status` is {carry, zero, negative, overflow} at bits [3:0]. Carry equals `r[W]` for add and subtract and is 0 otherwise. Zero is set when all of `r` is 0. Negative is `r[2W-1]` for multiply and `r[W-1]` otherwise. Overflow is the signed two's-complement overflow for add and subtract and is 0 otherwise.
- R10: With `freeze` high, `status` loads `status_in` for any code, while `r` still updates as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into the adder |
| opcode | input | 4 | Operation code |
| shamt | input | 4 | Shift distance |
| status_in | input | 4 | Flag vector loaded while frozen |
| freeze | input | 1 | Hold flags at `status_in` |
| r | output | 2W | Registered result |
| status | output | 4 | Registered flags {C,Z,N,V} |

## Verification
The assertions check the reset clearing, the freeze path, the clearing of carry and overflow for non-arithmetic codes, the zero flag's agreement with the result, the full product, the less-than bit and the empty upper half for narrow operations on every cycle. Sums, differences with their signed overflow, shift distances at and beyond the operand width, logic values, unused codes and a reset asserted in the middle of traffic are shown only by the bench. The bench compares every cycle against a behavioural model across all codes and operand pairs.

// File: rtl/alu_bypass_pkg.sv
package alu_bypass_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_NOT  = 4'd3,
        OP_AND  = 4'd4,
        OP_NAND = 4'd5,
        OP_OR   = 4'd6,
        OP_NOR  = 4'd7,
        OP_XOR  = 4'd8,
        OP_XNOR = 4'd9,
        OP_SHL  = 4'd10,
        OP_SHR  = 4'd11,
        OP_SLT  = 4'd12
    } alu_op_e;

    localparam int ST_W = 4;
    localparam int ST_C = 3;
    localparam int ST_Z = 2;
    localparam int ST_N = 1;
    localparam int ST_V = 0;

    typedef struct packed {
        logic arith;
        logic sub;
        logic mul;
        logic pass_a;
        logic land;
        logic lor;
        logic lxor;
        logic invert;
        logic shl;
        logic shr;
        logic slt;
        logic flag_upd;
    } unit_sel_t;

endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
    import alu_bypass_pkg::*;
(
    input  logic [3:0] opcode,
    input  logic       freeze,
    output unit_sel_t  sel
);
    always_comb begin
        sel = '0;
        case (opcode)
            OP_ADD:  sel.arith = 1'b1;
            OP_SUB:  begin sel.arith = 1'b1; sel.sub = 1'b1; end
            OP_MUL:  sel.mul = 1'b1;
            OP_NOT:  begin sel.pass_a = 1'b1; sel.invert = 1'b1; end
            OP_AND:  sel.land = 1'b1;
            OP_NAND: begin sel.land = 1'b1; sel.invert = 1'b1; end
            OP_OR:   sel.lor = 1'b1;
            OP_NOR:  begin sel.lor = 1'b1; sel.invert = 1'b1; end
            OP_XOR:  sel.lxor = 1'b1;
            OP_XNOR: begin sel.lxor = 1'b1; sel.invert = 1'b1; end
            OP_SHL:  sel.shl = 1'b1;
            OP_SHR:  sel.shr = 1'b1;
            OP_SLT:  sel.slt = 1'b1;
            default: sel = '0;
        endcase
        sel.flag_upd = ~freeze;
    end
endmodule

// File: rtl/alu_units.sv
module alu_units
    import alu_bypass_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    input  logic [3:0]     shamt,
    input  unit_sel_t      sel,
    output logic [W:0]     sum,
    output logic           ovf,
    output logic [2*W-1:0] prod,
    output logic [W-1:0]   logic_res,
    output logic [W-1:0]   shift_res,
    output logic           lt
);
    localparam int RW = 2 * W;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W-1:0] base;

    always_comb begin
        b_eff = sel.sub ? ~b : b;
        c_eff = sel.sub ? 1'b1 : cin;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

    assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    always_comb begin
        if (sel.land)      base = a & b;
        else if (sel.lor)  base = a | b;
        else if (sel.lxor) base = a ^ b;
        else               base = a;
        logic_res = sel.invert ? ~base : base;
    end

    always_comb begin
        if (sel.shl)      shift_res = a << shamt;
        else if (sel.shr) shift_res = a >> shamt;
        else              shift_res = '0;
    end

    assign lt = (a < b);

    logic unused_rw;
    assign unused_rw = (RW == 0);
endmodule

// File: rtl/alu_out_mux.sv
module alu_out_mux
    import alu_bypass_pkg::*;
#(
    parameter int W = 4
) (
    input  unit_sel_t       sel,
    input  logic [W:0]      sum,
    input  logic            ovf,
    input  logic [2*W-1:0]  prod,
    input  logic [W-1:0]    logic_res,
    input  logic [W-1:0]    shift_res,
    input  logic            lt,
    input  logic [ST_W-1:0] status_in,
    output logic [2*W-1:0]  r_nxt,
    output logic [ST_W-1:0] st_nxt
);
    localparam int RW = 2 * W;

    logic [ST_W-1:0] flags;

    always_comb begin
        r_nxt = '0;
        flags = '0;
        if (sel.arith) begin
            r_nxt       = {{(W-1){1'b0}}, sum};
            flags[ST_C] = sum[W];
            flags[ST_V] = ovf;
        end else if (sel.mul) begin
            r_nxt = prod;
        end else if (sel.pass_a | sel.land | sel.lor | sel.lxor) begin
            r_nxt = {{W{1'b0}}, logic_res};
        end else if (sel.shl | sel.shr) begin
            r_nxt = {{W{1'b0}}, shift_res};
        end else if (sel.slt) begin
            r_nxt = {{(RW-1){1'b0}}, lt};
        end
        flags[ST_Z] = (r_nxt == '0);
        flags[ST_N] = sel.mul ? r_nxt[RW-1] : r_nxt[W-1];
        st_nxt      = sel.flag_upd ? flags : status_in;
    end
endmodule

// File: rtl/alu_bypass_top.sv
module alu_bypass_top
    import alu_bypass_pkg::*;
#(
    parameter int W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    input  logic [3:0]      opcode,
    input  logic [3:0]      shamt,
    input  logic [ST_W-1:0] status_in,
    input  logic            freeze,
    output logic [2*W-1:0]  r,
    output logic [ST_W-1:0] status
);
    localparam int RW = 2 * W;

    unit_sel_t       sel;
    logic [W:0]      sum;
    logic            ovf;
    logic [RW-1:0]   prod;
    logic [W-1:0]    logic_res;
    logic [W-1:0]    shift_res;
    logic            lt;
    logic [RW-1:0]   r_nxt;
    logic [ST_W-1:0] st_nxt;

    alu_ctrl_dec dec_i (
        .opcode (opcode),
        .freeze (freeze),
        .sel    (sel)
    );

    alu_units #(.W(W)) units_i (
        .a         (a),
        .b         (b),
        .cin       (cin),
        .shamt     (shamt),
        .sel       (sel),
        .sum       (sum),
        .ovf       (ovf),
        .prod      (prod),
        .logic_res (logic_res),
        .shift_res (shift_res),
        .lt        (lt)
    );

    alu_out_mux #(.W(W)) mux_i (
        .sel       (sel),
        .sum       (sum),
        .ovf       (ovf),
        .prod      (prod),
        .logic_res (logic_res),
        .shift_res (shift_res),
        .lt        (lt),
        .status_in (status_in),
        .r_nxt     (r_nxt),
        .st_nxt    (st_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            r      <= '0;
            status <= '0;
        end else begin
            r      <= r_nxt;
            status <= st_nxt;
        end
    end
endmodule

// File: rtl/alu_bypass_chk.sv
module alu_bypass_chk
    import alu_bypass_pkg::*;
#(
    parameter int W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [W-1:0]    a,
    input logic [W-1:0]    b,
    input logic [3:0]      opcode,
    input logic [ST_W-1:0] status_in,
    input logic            freeze,
    input logic [2*W-1:0]  r,
    input logic [ST_W-1:0] status
);
    localparam int RW = 2 * W;

    logic narrow_op;
    assign narrow_op = (opcode >= 4'd3);

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (r == '0 && status == '0)); // R1
    AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        opcode == OP_MUL |=> r == ({{W{1'b0}}, $past(a)} * {{W{1'b0}}, $past(b)})); // R4
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        narrow_op |=> r[RW-1:W] == '0); // R5
    AST_SLT_BIT: assert property (@(posedge clk) disable iff (rst)
        opcode == OP_SLT |=> (r[RW-1:1] == '0 && r[0] == ($past(a) < $past(b)))); // R7
    AST_NO_ARITH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!freeze && opcode != OP_ADD && opcode != OP_SUB) |=> (!status[ST_C] && !status[ST_V])); // R9
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        !freeze |=> status[ST_Z] == (r == '0)); // R9
    AST_FREEZE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        freeze |=> status == $past(status_in)); // R10
endmodule

bind alu_bypass_top alu_bypass_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .a         (a),
    .b         (b),
    .opcode    (opcode),
    .status_in (status_in),
    .freeze    (freeze),
    .r         (r),
    .status    (status)
);

// File: tb/alu_bypass_top_tb_top.sv
module alu_bypass_top_tb_top;
    localparam int W  = 4;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  a = '0, b = '0;
    logic          cin = 1'b0;
    logic [3:0]    opcode = '0, shamt = '0, status_in = '0;
    logic          freeze = 1'b0;
    logic [RW-1:0] r;
    logic [3:0]    status;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    alu_bypass_top #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .opcode(opcode),
        .shamt(shamt), .status_in(status_in), .freeze(freeze),
        .r(r), .status(status)
    );

    function automatic string tag_of(int op);
        case (op)
            0:       return "R2";
            1:       return "R3";
            2:       return "R4";
            3, 4, 5, 6, 7, 8, 9: return "R5";
            10, 11:  return "R6";
            12:      return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(int op, int av, int bv, int ci, int sh, int sti, int fz);
        int res, c, v, n, z, st;
        a = av[3:0]; b = bv[3:0]; cin = ci[0]; opcode = op[3:0];
        shamt = sh[3:0]; status_in = sti[3:0]; freeze = fz[0];
        res = 0; c = 0; v = 0;
        case (op)
            0: begin
                res = av + bv + ci;
                c = (res >> 4) & 1;
                v = (((av >> 3) & 1) == ((bv >> 3) & 1)) && (((res >> 3) & 1) != ((av >> 3) & 1));
            end
            1: begin
                res = av + (15 - bv) + 1;
                c = (res >> 4) & 1;
                v = (((av >> 3) & 1) != ((bv >> 3) & 1)) && (((res >> 3) & 1) != ((av >> 3) & 1));
            end
            2:  res = av * bv;
            3:  res = 15 - av;
            4:  res = av & bv;
            5:  res = 15 - (av & bv);
            6:  res = av | bv;
            7:  res = 15 - (av | bv);
            8:  res = av ^ bv;
            9:  res = 15 - (av ^ bv);
            10: res = (sh >= 4) ? 0 : ((av << sh) & 15);
            11: res = (sh >= 4) ? 0 : (av >> sh);
            12: res = (av < bv) ? 1 : 0;
            default: res = 0;
        endcase
        n = (op == 2) ? ((res >> 7) & 1) : ((res >> 3) & 1);
        z = (res == 0) ? 1 : 0;
        st = fz ? sti : ((c << 3) | (z << 2) | (n << 1) | v);
        @(negedge clk);
        check(tag_of(op), int'(r), res);
        check(fz ? "R10" : "R9", int'(status), st);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1", int'(r), 0);
        check("R1", int'(status), 0);
        rst = 1'b0;
        // corner cases
        step(0, 15, 1, 0, 0, 0, 0);   // R2 carry-out, result 0x10
        step(0, 7, 1, 0, 0, 0, 0);    // R2 signed overflow
        step(0, 15, 0, 1, 0, 0, 0);   // R2 carry in
        step(1, 3, 5, 1, 0, 0, 0);    // R3 borrow, cin ignored
        step(1, 5, 5, 0, 0, 0, 0);    // R3 equal, zero low half
        step(1, 8, 1, 0, 0, 0, 0);    // R3 signed overflow
        step(2, 15, 15, 0, 0, 0, 0);  // R4 max product
        step(10, 9, 0, 0, 4, 0, 0);   // R6 distance equal to width
        step(11, 9, 0, 0, 15, 0, 0);  // R6 distance beyond width
        step(12, 2, 3, 0, 0, 0, 0);   // R7
        step(13, 7, 7, 1, 0, 0, 0);   // R8
        step(0, 15, 1, 0, 0, 10, 1);  // R10 frozen flags
        step(4, 0, 0, 0, 0, 5, 1);    // R10 frozen flags on logic
        // sweep all codes and operand pairs
        for (int op = 0; op < 16; op++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    step(op, x, y, (x + y) & 1, (x * 3 + y) & 15, (x ^ y ^ op) & 15,
                         ((x + y + op) % 7 == 0) ? 1 : 0);
        // reset in the middle of traffic
        a = 4'hF; b = 4'hF; opcode = 4'd2; freeze = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1", int'(r), 0);
        check("R1", int'(status), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule